// File: doc/BRIEF.md
# Rate-Smoothing Serial Stream Port

This block sits between a modem core and an external serial device. On the receive side the core delivers payload bits one at a time with a strobe. The stream has gaps: whole frames sometimes carry no payload. The block packs the bits into bytes and stores them in an elastic FIFO. It then sends them out as a continuous clock-and-data pair. The outgoing bit clock comes from a numerically controlled oscillator (NCO), which runs from the block's fast reference clock at a rate the host sets. The outgoing clock therefore keeps a constant period while the core pauses.

On the transmit side an external device supplies its own clock and data. The block synchronises both into the reference domain and captures a bit on each rising edge of the external clock. It hands each completed byte to the core with a one-cycle strobe.

A bypass mode switches off the elastic store and the oscillator. The raw receive bits then pass straight through, and the output clock pulses whenever the core strobes a bit, so it stays irregular.

The host loads the rate word only while reset is held. The FIFO's overflow and underflow events set sticky flags, and the host clears them with a pulse.

Top module: `stream_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `rx_clk_o`, `rx_dat_o`, `ovf_o`, `udf_o` and `core_tx_vld` are all 0.
- R2: Core bits are packed most significant bit first into bytes, and the bytes leave on `rx_dat_o` in arrival order, most significant bit first. `rx_dat_o` changes only in a cycle where `rx_clk_o` rises, so the bit is stable at the falling edge.
- R3: After reset, `rx_clk_o` stays low until the FIFO holds DEPTH/2 bytes. With the default DEPTH the first rising edge follows the 32nd complete byte.
- R4: In normal mode one full `rx_clk_o` period lasts 2·2^ACC_W / rate reference cycles. For example, rate 2^22 with ACC_W 24 gives a period of 8 cycles. The period does not change when the core pauses, as long as the FIFO is not empty.
- R5: The rate word is loaded only when `rate_wr` is high while `rst` is high. A write outside reset has no effect on the clock period. Rates up to 2^(ACC_W-2) are supported.
- R6: When a byte completes while the FIFO already holds DEPTH bytes, that byte is not stored and `ovf_o` is set. `ovf_o` stays set until it is cleared.
- R7: When a new byte must be sent and none is ready, the block sends the idle byte 0xFF and keeps the clock running. `udf_o` is set and stays set until it is cleared.
- R8: A one-cycle pulse on `status_clr` clears `ovf_o` and `udf_o` at the next clock edge. A clear takes priority over a new event in the same cycle.
- R9: On the transmit side, a bit is captured on each rising edge of `tx_clk_i` (after synchronisation), most significant bit first. Every eighth bit produces a one-cycle `core_tx_vld` pulse, with the byte on `core_tx_byte`.
- R10: In bypass mode (`bypass` = 1, changed only during reset), `rx_clk_o` is high exactly in the cycle after each `core_rx_vld` strobe and low otherwise. `rx_dat_o` carries the strobed bit and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_wr | input | 1 | Rate word write strobe, honoured only in reset |
| rate_wdata | input | ACC_W | NCO phase increment |
| bypass | input | 1 | 1 = raw pass-through of receive bits |
| status_clr | input | 1 | Clears both sticky flags |
| core_rx_vld | input | 1 | Core receive bit strobe |
| core_rx_bit | input | 1 | Core receive bit |
| rx_clk_o | output | 1 | Smoothed (or raw) receive bit clock |
| rx_dat_o | output | 1 | Receive serial data |
| tx_clk_i | input | 1 | External transmit clock, asynchronous |
| tx_dat_i | input | 1 | External transmit data |
| core_tx_vld | output | 1 | Byte-ready strobe toward core |
| core_tx_byte | output | 8 | Captured transmit byte |
| ovf_o | output | 1 | Sticky FIFO overflow flag |
| udf_o | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench uses the default DEPTH of 64 and the default 24-bit accumulator. The stream test runs at rate 2^22, which gives an exact 8-cycle bit period. The core side delivers one bit every 7 cycles, with a pause of one 8-byte frame, so the FIFO fills, reaches the start threshold and later runs dry. This one run exercises the start rule, the gap absorption and the idle fill. A second reset uses rate 2^16, which drains the FIFO so slowly that a back-to-back core burst overruns 64 bytes within a few hundred cycles. A transmit clock with a 20-cycle period exercises the two-stage synchroniser with wide margins.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sp_fifo.sv
// Elastic byte store. DEPTH must be a power of two; storage has no reset
// and a registered read so that block RAM can be inferred.
module sp_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  sp_pkg::byte_t  din,
  input  logic           pop,
  output sp_pkg::byte_t  dout,
  output logic [AW:0]    count,
  output logic           full,
  output logic           empty
);
  sp_pkg::byte_t mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic wr_ok, rd_ok;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
    if (rd_ok) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      unique case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sp_nco.sv
// Phase accumulator; the carry out is registered as a one-cycle tick.
module sp_nco #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_serializer.sv
// Each tick toggles the bit clock; on its rising half a new bit is shown.
// One byte is prefetched from the FIFO ahead of the load point.
module sp_serializer #(
  parameter sp_pkg::byte_t IDLE = 8'hFF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           started,
  input  logic           tick,
  input  logic           fifo_empty,
  input  sp_pkg::byte_t  fifo_dout,
  output logic           fifo_pop,
  output logic           sclk,
  output logic           sdat,
  output logic           underflow
);
  import sp_pkg::*;
  byte_t nxt, shreg;
  logic nxt_ok, inflight;
  logic [BIT_IDX_W-1:0] bidx;

  assign fifo_pop = started && !nxt_ok && !inflight && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt <= '0;
      shreg <= '0;
      nxt_ok <= 1'b0;
      inflight <= 1'b0;
      bidx <= '0;
      sclk <= 1'b0;
      sdat <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= 1'b0;
      inflight <= fifo_pop;
      if (tick) begin
        sclk <= ~sclk;
        if (!sclk) begin
          if (bidx == '0) begin
            if (nxt_ok) begin
              sdat <= nxt[BYTE_W-1];
              shreg <= {nxt[BYTE_W-2:0], 1'b0};
              nxt_ok <= 1'b0;
            end else begin
              sdat <= IDLE[BYTE_W-1];
              shreg <= {IDLE[BYTE_W-2:0], 1'b0};
              underflow <= 1'b1;
            end
          end else begin
            sdat <= shreg[BYTE_W-1];
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
          end
          bidx <= (bidx == BIT_IDX_W'(BYTE_W-1)) ? '0 : bidx + 1'b1;
        end
      end
      if (inflight) begin
        nxt <= fifo_dout;
        nxt_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_deserializer.sv
// Synchronises an external clock/data pair and packs bits MSB first.
module sp_deserializer #(
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ext_clk,
  input  logic           ext_dat,
  output logic           vld,
  output sp_pkg::byte_t  byte_o
);
  import sp_pkg::*;
  logic [SYNC-1:0] cs, ds;
  logic prev;
  logic rise;
  byte_t sh;
  logic [BIT_IDX_W-1:0] cnt;

  assign rise = cs[SYNC-1] && !prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs <= '0;
      ds <= '0;
      prev <= 1'b0;
      sh <= '0;
      cnt <= '0;
      vld <= 1'b0;
      byte_o <= '0;
    end else begin
      cs <= {cs[SYNC-2:0], ext_clk};
      ds <= {ds[SYNC-2:0], ext_dat};
      prev <= cs[SYNC-1];
      vld <= 1'b0;
      if (rise) begin
        sh <= {sh[BYTE_W-2:0], ds[SYNC-1]};
        cnt <= cnt + 1'b1;
        if (cnt == BIT_IDX_W'(BYTE_W-1)) begin
          byte_o <= {sh[BYTE_W-2:0], ds[SYNC-1]};
          vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stream_port.sv
module stream_port #(
  parameter int DEPTH = 64,
  parameter int ACC_W = 24,
  parameter int SYNC = 2,
  parameter logic [7:0] IDLE = 8'hFF,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_wr,
  input  logic [ACC_W-1:0] rate_wdata,
  input  logic             bypass,
  input  logic             status_clr,
  input  logic             core_rx_vld,
  input  logic             core_rx_bit,
  output logic             rx_clk_o,
  output logic             rx_dat_o,
  input  logic             tx_clk_i,
  input  logic             tx_dat_i,
  output logic             core_tx_vld,
  output logic [7:0]       core_tx_byte,
  output logic             ovf_o,
  output logic             udf_o
);
  import sp_pkg::*;
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

  logic [ACC_W-1:0] rate_q;
  logic started_q;
  byte_t asm_q, push_byte;
  logic [BIT_IDX_W-1:0] acnt;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty;
  byte_t fifo_dout;
  logic [AW:0] fifo_count;
  logic tick, ser_clk, ser_dat, ser_udf;

  // Rate word: accepted only while reset is held.
  always_ff @(posedge clk) begin
    if (rst && rate_wr) rate_q <= rate_wdata;
  end

  // Bit-to-byte packing of the core receive stream.
  always_ff @(posedge clk) begin
    if (rst) begin
      asm_q <= '0;
      acnt <= '0;
      fifo_push <= 1'b0;
      push_byte <= '0;
    end else begin
      fifo_push <= 1'b0;
      if (core_rx_vld && !bypass) begin
        asm_q <= {asm_q[BYTE_W-2:0], core_rx_bit};
        acnt <= acnt + 1'b1;
        if (acnt == BIT_IDX_W'(BYTE_W-1)) begin
          fifo_push <= 1'b1;
          push_byte <= {asm_q[BYTE_W-2:0], core_rx_bit};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) started_q <= 1'b0;
    else if (!bypass && fifo_count >= HALF) started_q <= 1'b1;
  end

  sp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .din(push_byte),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  sp_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst(rst), .en(started_q), .inc(rate_q), .tick(tick)
  );

  sp_serializer #(.IDLE(IDLE)) u_ser (
    .clk(clk), .rst(rst), .started(started_q), .tick(tick),
    .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .fifo_pop(fifo_pop),
    .sclk(ser_clk), .sdat(ser_dat), .underflow(ser_udf)
  );

  sp_deserializer #(.SYNC(SYNC)) u_des (
    .clk(clk), .rst(rst), .ext_clk(tx_clk_i), .ext_dat(tx_dat_i),
    .vld(core_tx_vld), .byte_o(core_tx_byte)
  );

  // Output select and sticky flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_clk_o <= 1'b0;
      rx_dat_o <= 1'b0;
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      if (bypass) begin
        rx_clk_o <= core_rx_vld;
        if (core_rx_vld) rx_dat_o <= core_rx_bit;
      end else begin
        rx_clk_o <= ser_clk;
        rx_dat_o <= ser_dat;
      end
      if (status_clr) begin
        ovf_o <= 1'b0;
        udf_o <= 1'b0;
      end else begin
        if (fifo_push && fifo_full) ovf_o <= 1'b1;
        if (ser_udf) udf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int DEPTH = 64,
  parameter int ACC_W = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             bypass,
  input logic             status_clr,
  input logic [ACC_W-1:0] rate_q,
  input logic             started,
  input logic             fifo_push,
  input logic [AW:0]      fifo_count,
  input logic             ovf,
  input logic             udf,
  input logic             rx_clk,
  input logic             rx_dat
);
  AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !started) |-> !rx_clk); // R3
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !$stable(rx_dat)) |-> $rose(rx_clk)); // R2
  AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(rate_q)); // R5
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= (AW+1)'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !status_clr) |=> ovf); // R6
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (udf && !status_clr) |=> udf); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    status_clr |=> (!ovf && !udf)); // R8
  AST_BYPASS_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !fifo_push); // R10
endmodule

bind stream_port sp_checker #(.DEPTH(DEPTH), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .bypass(bypass), .status_clr(status_clr),
  .rate_q(rate_q), .started(started_q), .fifo_push(fifo_push),
  .fifo_count(fifo_count), .ovf(ovf_o), .udf(udf_o),
  .rx_clk(rx_clk_o), .rx_dat(rx_dat_o)
);

// File: tb/stream_port_test.sv
`timescale 1ns/1ps
module stream_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_wr = 1'b0;
  logic [23:0] rate_wdata = '0;
  logic bypass = 1'b0;
  logic status_clr = 1'b0;
  logic core_rx_vld = 1'b0;
  logic core_rx_bit = 1'b0;
  logic rx_clk_o, rx_dat_o;
  logic tx_clk_i = 1'b0;
  logic tx_dat_i = 1'b0;
  logic core_tx_vld;
  logic [7:0] core_tx_byte;
  logic ovf_o, udf_o;

  stream_port uut (
    .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .bypass(bypass), .status_clr(status_clr), .core_rx_vld(core_rx_vld),
    .core_rx_bit(core_rx_bit), .rx_clk_o(rx_clk_o), .rx_dat_o(rx_dat_o),
    .tx_clk_i(tx_clk_i), .tx_dat_i(tx_dat_i), .core_tx_vld(core_tx_vld),
    .core_tx_byte(core_tx_byte), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Receive-side monitor
  logic mon_en = 1'b0;
  logic m_prev = 1'b0;
  int m_rises, m_last, per_err, exp_per, first_bytes, m_bits, rx_n;
  int bytes_done;
  logic [7:0] m_sh;
  logic [7:0] rx_buf [0:63];
  logic [7:0] sent [0:63];

  always @(negedge clk) begin
    if (mon_en) begin
      if (rx_clk_o && !m_prev) begin
        if (m_rises > 0 && (cyc - m_last) != exp_per) per_err++;
        if (m_rises == 0) first_bytes = bytes_done;
        m_last = cyc;
        m_rises++;
      end
      if (!rx_clk_o && m_prev) begin
        m_sh = {m_sh[6:0], rx_dat_o};
        m_bits++;
        if (m_bits == 8) begin
          if (rx_n < 64) rx_buf[rx_n] = m_sh;
          rx_n++;
          m_bits = 0;
        end
      end
    end
    m_prev = rx_clk_o;
  end

  // Transmit-side monitor
  int tx_n = 0;
  logic [7:0] tx_buf [0:7];
  always @(negedge clk) begin
    if (core_tx_vld) begin
      if (tx_n < 8) tx_buf[tx_n] = core_tx_byte;
      tx_n++;
    end
  end

  task automatic do_reset(input logic [23:0] rate, input logic byp);
    @(posedge clk); #1;
    rst = 1'b1; bypass = byp; rate_wr = 1'b1; rate_wdata = rate;
    core_rx_vld = 1'b0; status_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1; rate_wr = 1'b0; rst = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int spacing);
    @(posedge clk); #1;
    core_rx_vld = 1'b1; core_rx_bit = b;
    @(posedge clk); #1;
    core_rx_vld = 1'b0;
    repeat (spacing - 2) @(posedge clk);
  endtask

  task automatic test_reset();
    @(posedge clk); #1; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 rx_clk_o in reset", rx_clk_o, 0);
    check("R1 rx_dat_o in reset", rx_dat_o, 0);
    check("R1 ovf_o in reset", ovf_o, 0);
    check("R1 udf_o in reset", udf_o, 0);
    check("R1 core_tx_vld in reset", core_tx_vld, 0);
    do_reset(24'h400000, 1'b0);
    @(negedge clk);
    check("R1 rx_clk_o after reset", rx_clk_o, 0);
  endtask

  task automatic test_stream();
    do_reset(24'h400000, 1'b0);
    m_rises = 0; per_err = 0; exp_per = 8; m_bits = 0; rx_n = 0;
    bytes_done = 0; first_bytes = -1; m_prev = 1'b0;
    mon_en = 1'b1;
    for (int i = 0; i < 40; i++) sent[i] = 8'((i * 37 + 11) ^ (i << 3));
    for (int i = 0; i < 40; i++) begin
      if (i == 34) repeat (448) @(posedge clk);
      if (i == 10) begin
        @(posedge clk); #1; rate_wr = 1'b1; rate_wdata = 24'h100000;
        @(posedge clk); #1; rate_wr = 1'b0;
      end
      for (int b = 7; b >= 0; b--) send_bit(sent[i][b], 7);
      bytes_done++;
    end
    while (rx_n < 42) @(negedge clk);
    check("R3 bytes complete at first clock rise", first_bytes, 32);
    for (int i = 0; i < 40; i++) check("R2 byte order and value", rx_buf[i], sent[i]);
    check("R7 idle byte after drain", rx_buf[40], 8'hFF);
    check("R7 idle byte repeated", rx_buf[41], 8'hFF);
    check("R7 underflow flag", udf_o, 1);
    check("R6 no overflow in stream", ovf_o, 0);
    check("R4 R5 constant period through gap and late rate write", per_err, 0);
    check("R4 clock ran long enough", (m_rises > 300) ? 1 : 0, 1);
    // clear right after a clock rise, away from the next byte load
    @(negedge clk);
    while (!(rx_clk_o && !m_prev)) @(negedge clk);
    @(posedge clk); #1; status_clr = 1'b1;
    @(posedge clk); #1; status_clr = 1'b0;
    @(negedge clk);
    check("R8 underflow flag cleared", udf_o, 0);
    mon_en = 1'b0;
  endtask

  task automatic test_overflow();
    do_reset(24'h010000, 1'b0);
    for (int i = 0; i < 70; i++) begin
      for (int b = 7; b >= 0; b--) begin
        @(posedge clk); #1; core_rx_vld = 1'b1; core_rx_bit = b[0];
      end
    end
    @(posedge clk); #1; core_rx_vld = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 overflow flag", ovf_o, 1);
    check("R7 no underflow while full", udf_o, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R6 overflow flag sticky", ovf_o, 1);
    @(posedge clk); #1; status_clr = 1'b1;
    @(posedge clk); #1; status_clr = 1'b0;
    @(negedge clk);
    check("R8 overflow flag cleared", ovf_o, 0);
  endtask

  task automatic test_tx();
    logic [7:0] tv [0:3];
    tv[0] = 8'hA5; tv[1] = 8'h3C; tv[2] = 8'h81; tv[3] = 8'h7E;
    do_reset(24'h400000, 1'b0);
    tx_n = 0;
    for (int i = 0; i < 4; i++) begin
      for (int b = 7; b >= 0; b--) begin
        @(posedge clk); #1; tx_clk_i = 1'b0; tx_dat_i = tv[i][b];
        repeat (10) @(posedge clk);
        #1; tx_clk_i = 1'b1;
        repeat (9) @(posedge clk);
      end
    end
    @(posedge clk); #1; tx_clk_i = 1'b0;
    repeat (10) @(posedge clk);
    check("R9 transmit byte count", tx_n, 4);
    for (int i = 0; i < 4; i++) check("R9 transmit byte value", tx_buf[i], tv[i]);
  endtask

  task automatic test_bypass();
    logic [4:0] pat;
    pat = 5'b10110;
    do_reset(24'h400000, 1'b1);
    for (int i = 4; i >= 0; i--) begin
      @(posedge clk); #1; core_rx_vld = 1'b1; core_rx_bit = pat[i];
      @(posedge clk); #1; core_rx_vld = 1'b0;
      @(negedge clk);
      check("R10 clock pulse after strobe", rx_clk_o, 1);
      check("R10 data follows strobe", rx_dat_o, pat[i]);
      @(negedge clk);
      check("R10 clock low after pulse", rx_clk_o, 0);
      check("R10 data held", rx_dat_o, pat[i]);
      repeat (3) @(posedge clk);
    end
    begin
      int hi = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (rx_clk_o) hi++;
      end
      check("R10 no clock during core pause", hi, 0);
    end
    @(posedge clk); #1; bypass = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk); #1; rst = 1'b0;
  endtask

  initial begin
    test_reset();
    test_stream();
    test_overflow();
    test_tx();
    test_bypass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule